// File: doc/BRIEF.md
# ALU Status Flag Generator

This block is the arithmetic and logic stage of a small 16-bit datapath, together with the flag register that records how each operation ended. Each cycle it receives an operation code, two operands and a size select, byte or word. The result comes out combinationally in the same cycle. When the operation is marked valid, the flag register is updated on the next rising clock edge.

The low byte of the flag register holds six condition flags, each derived in its own way from the operands and the result. Three control flags sit in the upper byte: single-step trap, interrupt enable and string direction. Only explicit set, clear and load commands write them. Every other bit of the register reads as a fixed constant.

Top module: `alu_flags`

## Requirements
- R1: Operation codes are 0 add, 1 subtract (a minus b), 2 AND, 3 OR, 4 XOR, 5 increment a, 6 decrement a, 7 complement a, 8 shift a left by one, 9 logical shift a right by one, and 10 arithmetic shift a right by one. When word_mode is 0, only the low 8 bits of each operand are used and result bits 15:8 read zero.
- R2: Sign (bit 7) copies the top bit of the sized result, which is bit 7 in byte mode and bit 15 in word mode. Zero (bit 6) is set exactly when the sized result is all zeros.
- R3: Parity (bit 2) is set when result bits 7:0 hold an even number of ones. This holds in both sizes.
- R4: Carry (bit 0) is the carry out of the top bit on add, and the borrow on subtract. Increment and decrement leave carry unchanged.
- R5: Auxiliary carry (bit 4) is the carry out of bit 3 on add and increment, and the borrow into bit 4 on subtract and decrement.
- R6: Overflow (bit 11) is set when the signed result of an add, subtract, increment or decrement does not fit in the selected size.
- R7: AND, OR and XOR clear carry, overflow and auxiliary carry, and set sign, zero and parity from the result.
- R8: Complement changes no flag.
- R9: Shifts put the last bit shifted out into carry and clear auxiliary carry. Overflow becomes the new top bit XOR carry for a left shift, the original top bit for a logical right shift, and 0 for an arithmetic right shift.
- R10: Code 11 sets and code 12 clears the control flag that opnd_b[1:0] selects (0 trap at bit 8, 1 interrupt at bit 9, 2 direction at bit 10, 3 none). Codes 11 and 12 change no other bit.
- R11: Code 13 loads opnd_b into bits 0, 2, 4, 6, 7, 8, 9, 10 and 11. Bit 1 always reads 1, and bits 3, 5 and 15:12 always read 0. Reset leaves the register at 16'h0002.
- R12: ALU operations never change the control flags. While op_valid is low, or for codes 14 and 15, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Apply the operation to the flag register this cycle |
| op_code | input | 4 | Operation select |
| word_mode | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand, control-flag select, or load value |
| result | output | 16 | Combinational result of the ALU operation |
| flags | output | 16 | Flag register |

## Verification
Within one operation, the condition flags are rewritten while the control flags in the same register must stay untouched. On increment and decrement, five condition flags change while carry must keep its old value. The bench provokes both cases by streaming operations back to back, one per cycle, over a swept byte grid and over word values. Set, clear and load commands are interleaved with the stream, so the old carry and the control bits vary from one operation to the next. Each flag field is then compared separately against an arithmetic model that carries the previous register value forward, which shows whether an update leaked into a bit it must not touch.

// File: rtl/alu_flags.sv
module alu_flags (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [3:0]  op_code,
  input  logic        word_mode,
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  output logic [15:0] result,
  output logic [15:0] flags
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
                         OP_XOR = 4'd4, OP_INC = 4'd5, OP_DEC = 4'd6, OP_NOT = 4'd7,
                         OP_SHL = 4'd8, OP_SHR = 4'd9, OP_SAR = 4'd10, OP_SETC = 4'd11,
                         OP_CLRC = 4'd12, OP_LOAD = 4'd13;
  localparam logic [15:0] RW_MASK = 16'h0FD5;
  localparam logic [15:0] FIXED_ONES = 16'h0002;
  localparam int CF = 0, PF = 2, AF = 4, ZF = 6, SF = 7, OF = 11;

  logic [15:0] size_mask, top_bit, a_m, b_m, y, res;
  logic [16:0] raw;
  logic        is_sub, is_step, a_top, y_top, raw_top, r_top;
  logic        cf_n, af_n, of_n, stat_upd;

  assign size_mask = word_mode ? 16'hFFFF : 16'h00FF;
  assign top_bit   = word_mode ? 16'h8000 : 16'h0080;
  assign a_m       = opnd_a & size_mask;
  assign b_m       = opnd_b & size_mask;
  assign is_sub    = (op_code == OP_SUB) || (op_code == OP_DEC);
  assign is_step   = (op_code == OP_INC) || (op_code == OP_DEC);
  assign y         = is_step ? 16'd1 : b_m;
  assign raw       = is_sub ? ({1'b0, a_m} - {1'b0, y}) : ({1'b0, a_m} + {1'b0, y});
  assign a_top     = |(a_m & top_bit);
  assign y_top     = |(y & top_bit);
  assign raw_top   = |(raw[15:0] & top_bit);
  assign r_top     = |(res & top_bit);
  assign stat_upd  = op_valid && (op_code <= OP_SAR) && (op_code != OP_NOT);
  assign result    = res;

  always_comb begin
    res  = 16'h0000;
    cf_n = 1'b0;
    af_n = 1'b0;
    of_n = 1'b0;
    case (op_code)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        res  = raw[15:0] & size_mask;
        cf_n = word_mode ? raw[16] : raw[8];
        af_n = a_m[4] ^ y[4] ^ raw[4];
        of_n = is_sub ? ((a_top != y_top) && (raw_top != a_top))
                      : ((a_top == y_top) && (raw_top != a_top));
      end
      OP_AND: res = a_m & b_m;
      OP_OR:  res = a_m | b_m;
      OP_XOR: res = a_m ^ b_m;
      OP_NOT: res = ~a_m & size_mask;
      OP_SHL: begin
        res  = (a_m << 1) & size_mask;
        cf_n = a_top;
        of_n = a_top ^ (word_mode ? a_m[14] : a_m[6]);
      end
      OP_SHR: begin
        res  = a_m >> 1;
        cf_n = a_m[0];
        of_n = a_top;
      end
      OP_SAR: begin
        res  = (a_m >> 1) | (a_top ? top_bit : 16'h0000);
        cf_n = a_m[0];
      end
      default: res = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= FIXED_ONES;
    end else if (stat_upd) begin
      flags[CF] <= is_step ? flags[CF] : cf_n;
      flags[PF] <= ~^res[7:0];
      flags[AF] <= af_n;
      flags[ZF] <= (res == 16'h0000);
      flags[SF] <= r_top;
      flags[OF] <= of_n;
    end else if (op_valid && (op_code == OP_SETC || op_code == OP_CLRC)) begin
      case (opnd_b[1:0])
        2'd0:    flags[8]  <= (op_code == OP_SETC);
        2'd1:    flags[9]  <= (op_code == OP_SETC);
        2'd2:    flags[10] <= (op_code == OP_SETC);
        default: flags     <= flags;
      endcase
    end else if (op_valid && op_code == OP_LOAD) begin
      flags <= (opnd_b & RW_MASK) | FIXED_ONES;
    end
  end
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic        word_mode,
  input logic [15:0] opnd_a,
  input logic [15:0] opnd_b,
  input logic [15:0] result,
  input logic [15:0] flags
);
  // R11
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & 16'hF02A) == 16'h0002);
  // R12
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 4'd10) |=> $stable(flags[10:8]));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code >= 4'd14) |=> $stable(flags));
  // R8
  not_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd7) |=> $stable(flags));
  // R4
  step_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd5 || op_code == 4'd6)) |=> $stable(flags[0]));
  // R7
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 4'd2 && op_code <= 4'd4) |=> (!flags[0] && !flags[11] && !flags[4]));
  // R3
  parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 4'd10 && op_code != 4'd7) |=> (flags[2] == ~^$past(result[7:0])));
  // R2
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 4'd10 && op_code != 4'd7) |=> (flags[6] == ($past(result) == 16'h0000)));
  // R1
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> (result[15:8] == 8'h00));
endmodule

bind alu_flags alu_flags_chk chk (.*);

// File: tb/alu_flags_test.sv
module alu_flags_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic        word_mode = 1'b0;
  logic [15:0] opnd_a = 16'h0;
  logic [15:0] opnd_b = 16'h0;
  logic [15:0] result;
  logic [15:0] flags;

  int n_chk = 0;
  int n_err = 0;
  int mf = 16'h0002;
  int e_res = 0;
  int e_fl = 0;
  int unsigned seed = 32'h1234_5678;

  alu_flags uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
                 .word_mode(word_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
                 .result(result), .flags(flags));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s op=%0d w=%0d a=%h b=%h got=%h exp=%h",
               tag, op_code, word_mode, opnd_a, opnd_b, got, exp);
    end
  endtask

  function automatic int bitv(input int v, input int n);
    return (v >> n) & 1;
  endfunction

  task automatic model(input int op, input int w, input int a_in, input int b_in);
    int md, half, a, b, s, r, cf, af, of_, sa, sb, sr, f;
    md = w ? 65536 : 256;
    half = md / 2;
    a = a_in % md;
    b = b_in % md;
    cf = 0; af = 0; of_ = 0; r = 0;
    if (op == 5 || op == 6) b = 1;
    sa = (a >= half) ? a - md : a;
    sb = (b >= half) ? b - md : b;
    case (op)
      0, 5: begin
        s = a + b; r = s % md; cf = (s >= md) ? 1 : 0;
        af = ((a % 16) + (b % 16) > 15) ? 1 : 0;
        sr = sa + sb; of_ = (sr >= half || sr < -half) ? 1 : 0;
      end
      1, 6: begin
        s = a - b; r = (s + md) % md; cf = (a < b) ? 1 : 0;
        af = ((a % 16) < (b % 16)) ? 1 : 0;
        sr = sa - sb; of_ = (sr >= half || sr < -half) ? 1 : 0;
      end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      7: r = (md - 1) - a;
      8: begin r = (a * 2) % md; cf = (a >= half) ? 1 : 0; of_ = ((r >= half) ? 1 : 0) ^ cf; end
      9: begin r = a / 2; cf = a % 2; of_ = (a >= half) ? 1 : 0; end
      10: begin r = a / 2 + ((a >= half) ? half : 0); cf = a % 2; end
      default: r = 0;
    endcase
    e_res = r;
    f = mf;
    if (op <= 10 && op != 7) begin
      if (op == 5 || op == 6) cf = bitv(mf, 0);
      f = (mf & 16'h0700) | 16'h0002 | cf | (af << 4) | (of_ << 11)
          | ((r >= half) ? 16'h0080 : 0) | ((r == 0) ? 16'h0040 : 0)
          | (($countones(r % 256) % 2 == 0) ? 16'h0004 : 0);
    end else if (op == 11 && (b_in % 4) != 3) begin
      f = mf | (1 << (8 + b_in % 4));
    end else if (op == 12 && (b_in % 4) != 3) begin
      f = mf & ~(1 << (8 + b_in % 4));
    end else if (op == 13) begin
      f = (b_in & 16'h0FD5) | 16'h0002;
    end
    e_fl = f;
  endtask

  task automatic issue(input int op, input int w, input int a, input int b);
    op_valid = 1'b1;
    op_code = op[3:0];
    word_mode = w[0];
    opnd_a = a[15:0];
    opnd_b = b[15:0];
    model(op, w, a, b);
    #1;
    if (op <= 10) chk("R1", result, e_res);
    @(negedge clk);
    if (op <= 1 || op == 5 || op == 6) begin
      chk("R2", flags & 16'h00C0, e_fl & 16'h00C0);
      chk("R3", bitv(flags, 2), bitv(e_fl, 2));
      chk("R4", bitv(flags, 0), bitv(e_fl, 0));
      chk("R5", bitv(flags, 4), bitv(e_fl, 4));
      chk("R6", bitv(flags, 11), bitv(e_fl, 11));
      chk("R12", flags & 16'hF72A, e_fl & 16'hF72A);
    end else if (op <= 4) chk("R7", flags, e_fl);
    else if (op == 7) chk("R8", flags, e_fl);
    else if (op <= 10) chk("R9", flags, e_fl);
    else if (op <= 12) chk("R10", flags, e_fl);
    else if (op == 13) chk("R11", flags, e_fl);
    else chk("R12", flags, e_fl);
    mf = e_fl;
  endtask

  function automatic int unsigned nxt(input int unsigned s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", flags, 16'h0002);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", flags, 16'h0002);

    issue(13, 1, 0, 16'hFFFF);
    issue(11, 1, 0, 3);
    issue(12, 1, 0, 0);
    issue(12, 1, 0, 1);
    issue(11, 1, 0, 2);
    issue(14, 1, 16'h1234, 16'hFFFF);
    op_valid = 1'b0;
    op_code = 4'd0;
    @(negedge clk);
    chk("R12", flags, mf);

    issue(0, 1, 16'h7FFF, 16'h0001);
    issue(0, 1, 16'hFFFF, 16'h0001);
    issue(1, 1, 16'h8000, 16'h0001);
    issue(5, 1, 16'h7FFF, 0);
    issue(6, 1, 16'h0000, 0);
    issue(8, 1, 16'hC000, 0);
    issue(10, 1, 16'h8001, 0);
    issue(0, 0, 16'hAB7F, 16'hCD01);
    issue(7, 0, 16'hFF0F, 0);

    for (int op = 0; op <= 10; op++)
      for (int a = 0; a < 256; a += 5)
        for (int b = 0; b < 256; b += 7) begin
          if (b == 0 && a % 25 == 0) issue(11 + (a / 25) % 3, 0, 0, a / 25);
          issue(op, 0, a, b);
        end

    for (int i = 0; i < 4000; i++) begin
      int op, av, bv;
      seed = nxt(seed);
      op = int'(seed[19:16]);
      av = int'(seed[31:16]);
      seed = nxt(seed);
      bv = int'(seed[31:16]);
      if (i % 7 == 0) av = 16'h7FF0 + i % 32;
      issue(op, 1, av, bv);
    end

    op_valid = 1'b0;
    @(negedge clk);
    chk("R12", flags, mf);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule